// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

A single-channel transfer engine that the processor sets up through four small registers: a control word, a device address, a memory address and a word count. Once started, the engine moves the whole block on its own. For every word it asks the shared bus for ownership, reads one word from the source port, and writes it to the destination port. It then drops its request at once, so the processor goes on between its own bus cycles. This stolen cycle is not an interrupt and the processor's context is never touched.

The device address stays fixed for the whole transfer. The memory address advances by one per word, and the count falls to zero. When the last word lands, the engine raises a done flag and an interrupt line. Both stay up until software clears them. Both data ports are simple single-word valid/ready ports.

Top module: `cs_dma`

## Requirements
- R1: Register writes use `cfg_addr` 0 for control, 1 for device address, 2 for memory address and 3 for word count. Reads at addresses 1 to 3 return the current value. A read at address 0 returns busy in bit 0, done in bit 1 and direction in bit 2.
- R2: A control write with bit 0 set (start) while idle makes the engine busy, and `bus_req` is high in the following cycle. The engine then finishes the block with no further register access.
- R3: Exactly one word moves per bus ownership. After the destination accepts a word, `bus_req` is low for at least one cycle, so the number of `bus_req` rising edges equals the word count.
- R4: Neither port strobe is asserted while `bus_grant` is low. While the grant is withheld, the count and memory address do not advance.
- R5: With control bit 1 clear, each word is read from the device at the fixed device address and written to memory at the memory address, which increases by one per word.
- R6: With control bit 1 set, each word is read from memory at the increasing memory address and written to the device at the fixed device address.
- R7: After the last word, done and `irq` go high and busy goes low. The memory address register reads start plus count, and the count register reads 0.
- R8: Done and `irq` stay high until a control write with bit 2 set (clear) or a new start.
- R9: While busy, a start and writes to the address and count registers are ignored.
- R10: A start with a count of 0 sets done and `irq` in the next cycle and never requests the bus.
- R11: After reset the engine is idle, and `bus_req`, `irq` and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt request |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| dev_addr | output | AW | Device address |
| dev_valid | output | 1 | Device access strobe |
| dev_write | output | 1 | Device access is a write |
| dev_wdata | output | DW | Device write data |
| dev_rdata | input | DW | Device read data |
| dev_ready | input | 1 | Device accepts access |
| mem_addr | output | AW | Memory address |
| mem_valid | output | 1 | Memory access strobe |
| mem_write | output | 1 | Memory access is a write |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Memory accepts access |

## Verification
The bench builds the engine with 8-bit addresses and counts and 16-bit data and registers. With these values a behavioural 256-word memory can hold every block a test touches, and readback of address and count registers is exact. The bench arbiter grants one cycle after each request, and the device inserts one wait state per access. Together they exercise the request/release spacing and the stall path on every word. A switch in the arbiter withholds the grant to reach the stalled case.

// File: rtl/cs_dma.sv
module cs_dma #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] dev_addr,
  output logic          dev_valid,
  output logic          dev_write,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  input  logic          dev_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_REL} st_t;

  st_t           st;
  logic          dir_q, done_q;
  logic [AW-1:0] dev_q, mem_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] buf_q;

  logic busy, ctl_wr, go, rd_valid, wr_valid, rd_fire, wr_fire, last;

  assign busy     = (st != S_IDLE);
  assign ctl_wr   = cfg_we && (cfg_addr == 2'd0);
  assign go       = ctl_wr && cfg_wdata[0] && !busy;
  assign rd_valid = (st == S_RD) && bus_grant;
  assign wr_valid = (st == S_WR) && bus_grant;
  assign rd_fire  = rd_valid && (dir_q ? mem_ready : dev_ready);
  assign wr_fire  = wr_valid && (dir_q ? dev_ready : mem_ready);
  assign last     = (cnt_q == CW'(1));

  assign bus_req   = (st == S_REQ) || (st == S_RD) || (st == S_WR);
  assign irq       = done_q;
  assign dev_addr  = dev_q;
  assign mem_addr  = mem_q;
  assign dev_wdata = buf_q;
  assign mem_wdata = buf_q;
  assign dev_write = dir_q;
  assign mem_write = !dir_q;
  assign dev_valid = dir_q ? wr_valid : rd_valid;
  assign mem_valid = dir_q ? rd_valid : wr_valid;

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = RW'({dir_q, done_q, busy});
      2'd1:    cfg_rdata = RW'(dev_q);
      2'd2:    cfg_rdata = RW'(mem_q);
      default: cfg_rdata = RW'(cnt_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      dev_q  <= '0;
      mem_q  <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
    end else begin
      if (cfg_we && !busy) begin
        case (cfg_addr)
          2'd0:    dir_q <= cfg_wdata[1];
          2'd1:    dev_q <= cfg_wdata[AW-1:0];
          2'd2:    mem_q <= cfg_wdata[AW-1:0];
          default: cnt_q <= cfg_wdata[CW-1:0];
        endcase
      end

      if (go && cnt_q == '0)
        done_q <= 1'b1;
      else if (wr_fire && last)
        done_q <= 1'b1;
      else if (ctl_wr && (cfg_wdata[2] || go))
        done_q <= 1'b0;

      case (st)
        S_IDLE: if (go && cnt_q != '0) st <= S_REQ;
        S_REQ:  if (bus_grant) st <= S_RD;
        S_RD:   if (rd_fire) begin
                  buf_q <= dir_q ? mem_rdata : dev_rdata;
                  st    <= S_WR;
                end
        S_WR:   if (wr_fire) begin
                  mem_q <= mem_q + 1'b1;
                  cnt_q <= cnt_q - 1'b1;
                  st    <= last ? S_IDLE : S_REL;
                end
        default: st <= S_REQ;
      endcase
    end
  end

  assert_release_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !bus_req);

  assert_stall_without_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_grant) |=> ($stable(cnt_q) && $stable(mem_q)));

  assert_dev_addr_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dev_addr));

  assert_mem_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  assert_irq_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !bus_req);

  assert_count_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && cfg_addr == 2'd3 && !wr_fire) |=> $stable(cnt_q));

endmodule

// File: tb/cs_dma_test.sv
`timescale 1ns/1ps
module cs_dma_test;
  localparam int AW = 8, DW = 16, CW = 8, RW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [RW-1:0] cfg_wdata = 0, cfg_rdata;
  logic irq, bus_req, bus_grant = 0;
  logic [AW-1:0] dev_addr, mem_addr;
  logic dev_valid, dev_write, dev_ready, mem_valid, mem_write, mem_ready;
  logic [DW-1:0] dev_wdata, dev_rdata, mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  logic grant_block = 0, dev_wait = 0, prev_req = 0;
  int rd_cnt = 0, req_rises = 0, viol = 0, wcnt = 0, bad_dev_addr = 0;
  logic [AW-1:0] exp_dev = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] wlog [16];

  always #10 clk = ~clk;

  cs_dma #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .dev_addr(dev_addr), .dev_valid(dev_valid), .dev_write(dev_write),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ready(dev_ready),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  assign dev_ready = dev_valid && dev_wait;
  assign dev_rdata = DW'(16'hA000 + rd_cnt);
  assign mem_ready = mem_valid;
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    bus_grant <= rst_n && bus_req && !grant_block;
    dev_wait  <= dev_valid && !dev_ready;
    prev_req  <= bus_req;
    if (bus_req && !prev_req) req_rises <= req_rises + 1;
    if (dev_valid && dev_ready) begin
      if (dev_addr != exp_dev) bad_dev_addr <= bad_dev_addr + 1;
      if (dev_write) begin
        wlog[wcnt[3:0]] <= dev_wdata;
        wcnt <= wcnt + 1;
      end else rd_cnt <= rd_cnt + 1;
    end
    if (mem_valid && mem_ready && mem_write) mem[mem_addr] <= mem_wdata;
  end

  always @(negedge clk)
    if ((dev_valid || mem_valid) && !bus_grant) viol <= viol + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = RW'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    cfg_addr = a;
    #1 d = int'(cfg_rdata);
  endtask

  task automatic wait_idle();
    int s;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd0, s);
      if ((s & 1) == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic setup(int dv, int ma, int n);
    exp_dev = AW'(dv);
    wr(2'd1, dv); wr(2'd2, ma); wr(2'd3, n);
  endtask

  task automatic t_reset();
    int v;
    rd(2'd0, v); check("R11 status", v, 0);
    rd(2'd2, v); check("R11 mem reg", v, 0);
    check("R11 irq", irq, 0);
    check("R11 bus_req", bus_req, 0);
  endtask

  task automatic t_dev_to_mem();
    int base, r0, v;
    for (int i = 0; i < 8; i++) mem[8'h10 + i] = 0;
    setup(8'h33, 8'h10, 5);
    base = rd_cnt; r0 = req_rises;
    wr(2'd0, 1);
    check("R2 bus_req after start", bus_req, 1);
    rd(2'd0, v); check("R2 busy", v & 1, 1);
    wait_idle();
    for (int i = 0; i < 5; i++)
      check("R5 memory word", mem[8'h10 + i], 16'hA000 + base + i);
    check("R5 no overrun", mem[8'h15], 0);
    check("R5 device address fixed", bad_dev_addr, 0);
    check("R3 one request per word", req_rises - r0, 5);
    check("R7 irq", irq, 1);
    rd(2'd0, v); check("R7 status done idle", v & 3, 2);
    rd(2'd2, v); check("R7 mem reg end", v, 8'h15);
    rd(2'd3, v); check("R7 count zero", v, 0);
  endtask

  task automatic t_hold_clear();
    int v;
    repeat (10) @(negedge clk);
    check("R8 irq held", irq, 1);
    wr(2'd0, 4);
    check("R8 irq cleared", irq, 0);
    rd(2'd0, v); check("R8 done cleared", v & 2, 0);
  endtask

  task automatic t_mem_to_dev();
    int w0;
    for (int i = 0; i < 4; i++) mem[8'h40 + i] = DW'(16'h5500 + i * 3);
    setup(8'h07, 8'h40, 4);
    w0 = wcnt;
    wr(2'd0, 3);
    wait_idle();
    check("R6 device write count", wcnt - w0, 4);
    for (int i = 0; i < 4; i++)
      check("R6 device word", wlog[(w0 + i) % 16], 16'h5500 + i * 3);
    check("R6 device address fixed", bad_dev_addr, 0);
    check("R7 irq after read-out", irq, 1);
  endtask

  task automatic t_busy_ignore();
    int v;
    for (int i = 0; i < 16; i++) mem[8'h80 + i] = 0;
    setup(8'h01, 8'h80, 3);
    wr(2'd0, 1);
    check("R8 start clears done", irq, 0);
    wr(2'd3, 20);
    wr(2'd2, 8'h88);
    wr(2'd0, 3);
    wait_idle();
    check("R9 word 2 written", mem[8'h82] != 0, 1);
    check("R9 only three words", mem[8'h83], 0);
    check("R9 address write ignored", mem[8'h88], 0);
    rd(2'd2, v); check("R9 mem reg end", v, 8'h83);
    rd(2'd0, v); check("R9 direction kept", v & 4, 0);
  endtask

  task automatic t_zero();
    int r0;
    setup(8'h01, 8'h90, 0);
    r0 = req_rises;
    wr(2'd0, 1);
    check("R10 irq at once", irq, 1);
    check("R10 no bus_req", bus_req, 0);
    repeat (5) @(negedge clk);
    check("R10 no request edges", req_rises - r0, 0);
  endtask

  task automatic t_no_grant();
    int v;
    mem[8'hA0] = 0; mem[8'hA1] = 0;
    setup(8'h02, 8'hA0, 2);
    grant_block = 1;
    wr(2'd0, 1);
    repeat (20) @(negedge clk);
    rd(2'd3, v); check("R4 count stalled", v, 2);
    rd(2'd2, v); check("R4 address stalled", v, 8'hA0);
    check("R4 memory untouched", mem[8'hA0], 0);
    grant_block = 0;
    wait_idle();
    check("R4 completes after grant", mem[8'hA1] != 0, 1);
    check("R4 no strobe without grant", viol, 0);
    rd(2'd1, v); check("R1 device reg readback", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dev_to_mem();
    t_hold_clear();
    t_mem_to_dev();
    t_busy_ignore();
    t_zero();
    t_no_grant();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule